// File: doc/BRIEF.md
# Dual-Page Connection Map Store

This block holds the switching map of a time-slot interchange. Output slots are grouped into channels of `SLOTS` (default 12) slots. Each channel owns two configuration pages, A and B. Each page holds two alternate maps, C and D, with one `IDX_W`-bit source index for each output slot. Each channel has one bit that names its active page. The interchange asks for the entry of one (channel, output slot) pair per cycle. The block returns the source index taken from the channel's active page. The map comes from a per-slot select register, so alternates can be chosen one slot at a time while pages switch a whole channel at once.

A processor port fills the standby page and can read back any entry. A separate read port serves read-back, so read-back never takes a cycle from the lookup path. The processor requests a page swap for a channel. The swap waits for the next frame boundary, so the traffic path never sees a half-written page.

Top module: `cmap_conn_mem`

## Requirements
- R1: After reset, every stored entry reads as 0, every channel's active page is A (`cfg_active` bit 0), every map-select bit is 0, and `out_valid` and `cpu_rvalid` are low.
- R2: When `lk_valid` is high with a legal channel and slot, `out_valid` is high in the next cycle. In that cycle `out_idx` holds the entry of that channel's active page, at the map chosen for that slot. With no request, `out_valid` is low and `out_idx` is 0.
- R3: Bit s of a channel's map-select word chooses the map for output slot s: 0 selects map C (page offset s), 1 selects map D (page offset `SLOTS`+s). A new word written with `msel_wr` applies to lookups presented in the following cycle.
- R4: A processor write (`cpu_wr`) stores `cpu_wdata` at (channel, `cpu_page`, `cpu_map`, slot) only when `cpu_page` is the channel's standby page. A write aimed at the active page leaves the stored entry unchanged.
- R5: `swap_req` marks `swap_ch` as pending. At the next cycle with `frame_sync` high, every pending channel toggles its active page and its pending mark is cleared. A request raised in the same cycle as `frame_sync` waits for the following boundary. Without `frame_sync`, `cfg_active` does not change.
- R6: `cpu_rd` with a legal address raises `cpu_rvalid` in the next cycle, with `cpu_rdata` holding the entry of either page. A write to the same entry in the same cycle yields the old value. A lookup presented in the same cycle still returns its own correct result.
- R7: A slot index of `SLOTS` or more is illegal. A lookup or read-back with an illegal slot gives a low valid and a zero data output. A write with an illegal slot changes nothing.
- R8: A swap affects only the channels that were pending. The pages and map selects of all other channels stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | Frame boundary pulse; pending swaps apply here |
| lk_valid | input | 1 | Lookup request |
| lk_ch | input | CH_W | Lookup channel |
| lk_slot | input | SLOT_W | Lookup output slot within the channel |
| out_valid | output | 1 | Lookup result valid, one cycle after request |
| out_idx | output | IDX_W | Source index returned by the lookup |
| cpu_wr | input | 1 | Processor entry write strobe |
| cpu_rd | input | 1 | Processor entry read strobe |
| cpu_ch | input | CH_W | Processor channel |
| cpu_page | input | 1 | Processor page, 0 = A, 1 = B |
| cpu_map | input | 1 | Processor map, 0 = C, 1 = D |
| cpu_slot | input | SLOT_W | Processor slot |
| cpu_wdata | input | IDX_W | Processor write data |
| cpu_rvalid | output | 1 | Read-back data valid |
| cpu_rdata | output | IDX_W | Read-back data |
| msel_wr | input | 1 | Map-select word write strobe |
| msel_ch | input | CH_W | Channel of map-select write |
| msel_data | input | SLOTS | Map-select word, bit s for slot s |
| swap_req | input | 1 | Page swap request |
| swap_ch | input | CH_W | Channel of swap request |
| cfg_active | output | N_CH | Active page per channel, 0 = A, 1 = B |

## Verification
The assertions assume that `rst_n` is asserted before any other stimulus is applied and that every strobe is a level sampled once per clock. They make no assumption about illegal slot values, because those values are part of the defined behaviour. The stimulus changes inputs only on falling edges and raises at most one processor operation per cycle, except in the directed cases that overlap a read with a write or a lookup on purpose. Random channel, page, map and slot values are drawn from the full port widths, so illegal slots and writes to active pages both occur.

// File: rtl/cmap_pkg.sv
package cmap_pkg;
   typedef enum logic {PG_A = 1'b0, PG_B = 1'b1} page_e;
   typedef enum logic {MAP_C = 1'b0, MAP_D = 1'b1} map_e;

   // linear entry position: channel, then page, then map, then slot
   function automatic int unsigned lin_addr(int unsigned ch, int unsigned pg,
                                            int unsigned mp, int unsigned sl,
                                            int unsigned slots);
      return ((ch * 2 + pg) * 2 + mp) * slots + sl;
   endfunction
endpackage

// File: rtl/cmap_store.sv
module cmap_store #(
   parameter int DEPTH = 192,
   parameter int AW    = 8,
   parameter int DW    = 10,
   parameter int NRD   = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [AW-1:0]            waddr,
   input  logic [DW-1:0]            wdata,
   input  logic [NRD-1:0]           rd_en,
   input  logic [NRD-1:0][AW-1:0]   rd_addr,
   output logic [NRD-1:0][DW-1:0]   rd_data
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        rd_data[p] <= '0;
         else if (rd_en[p]) rd_data[p] <= mem[rd_addr[p]];
         else               rd_data[p] <= '0;
      end
   end
endmodule

// File: rtl/cmap_page_ctl.sv
module cmap_page_ctl #(
   parameter int N_CH = 4,
   parameter int CH_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            frame_sync,
   input  logic            swap_req,
   input  logic [CH_W-1:0] swap_ch,
   output logic [N_CH-1:0] active
);
   logic [N_CH-1:0] pending;

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      logic hit;
      assign hit = swap_req && (swap_ch == CH_W'(c));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            active[c]  <= 1'b0;
            pending[c] <= 1'b0;
         end else begin
            if (frame_sync && pending[c]) active[c] <= ~active[c];
            pending[c] <= (pending[c] && !frame_sync) || hit;
         end
      end
   end
endmodule

// File: rtl/cmap_msel_regs.sv
module cmap_msel_regs #(
   parameter int N_CH  = 4,
   parameter int CH_W  = 2,
   parameter int SLOTS = 12
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr,
   input  logic [CH_W-1:0]             ch,
   input  logic [SLOTS-1:0]            data,
   output logic [N_CH-1:0][SLOTS-1:0]  sel
);
   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        sel[c] <= '0;
         else if (wr && ch == CH_W'(c))     sel[c] <= data;
      end
   end
endmodule

// File: rtl/cmap_conn_mem.sv
module cmap_conn_mem #(
   parameter int N_CH   = 4,
   parameter int SLOTS  = 12,
   parameter int IDX_W  = 10,
   localparam int CH_W   = $clog2(N_CH),
   localparam int SLOT_W = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_sync,
   input  logic              lk_valid,
   input  logic [CH_W-1:0]   lk_ch,
   input  logic [SLOT_W-1:0] lk_slot,
   output logic              out_valid,
   output logic [IDX_W-1:0]  out_idx,
   input  logic              cpu_wr,
   input  logic              cpu_rd,
   input  logic [CH_W-1:0]   cpu_ch,
   input  logic              cpu_page,
   input  logic              cpu_map,
   input  logic [SLOT_W-1:0] cpu_slot,
   input  logic [IDX_W-1:0]  cpu_wdata,
   output logic              cpu_rvalid,
   output logic [IDX_W-1:0]  cpu_rdata,
   input  logic              msel_wr,
   input  logic [CH_W-1:0]   msel_ch,
   input  logic [SLOTS-1:0]  msel_data,
   input  logic              swap_req,
   input  logic [CH_W-1:0]   swap_ch,
   output logic [N_CH-1:0]   cfg_active
);
   import cmap_pkg::*;

   localparam int DEPTH = N_CH * 4 * SLOTS;
   localparam int AW    = $clog2(DEPTH);
   localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);
   localparam logic [CH_W-1:0]   CH_LAST   = CH_W'(N_CH - 1);

   if (N_CH < 2)                 begin : g_bad_ch   $error("N_CH must be at least 2");        end
   if (SLOTS < 2)                begin : g_bad_sl   $error("SLOTS must be at least 2");       end
   if (IDX_W < 1 || IDX_W > 16)  begin : g_bad_w    $error("IDX_W must be within 1..16");     end

   logic [N_CH-1:0][SLOTS-1:0] msel;
   logic lk_ok, rd_ok, wr_ok;
   page_e lk_pg;
   map_e  lk_mp;
   logic [1:0]           rd_en;
   logic [1:0][AW-1:0]   rd_addr;
   logic [1:0][IDX_W-1:0] rd_data;
   logic [AW-1:0]        wr_addr;
   logic                 lk_q, rd_q;

   cmap_page_ctl #(.N_CH(N_CH), .CH_W(CH_W)) u_pages (
      .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
      .swap_req(swap_req), .swap_ch(swap_ch), .active(cfg_active));

   cmap_msel_regs #(.N_CH(N_CH), .CH_W(CH_W), .SLOTS(SLOTS)) u_msel (
      .clk(clk), .rst_n(rst_n), .wr(msel_wr), .ch(msel_ch),
      .data(msel_data), .sel(msel));

   always_comb begin
      lk_ok = lk_valid && (lk_slot <= SLOT_LAST) && (lk_ch <= CH_LAST);
      rd_ok = cpu_rd   && (cpu_slot <= SLOT_LAST) && (cpu_ch <= CH_LAST);
      wr_ok = cpu_wr   && (cpu_slot <= SLOT_LAST) && (cpu_ch <= CH_LAST)
              && (cpu_page != cfg_active[cpu_ch]);
      lk_pg = page_e'(cfg_active[lk_ch]);
      lk_mp = lk_ok ? map_e'(msel[lk_ch][lk_slot]) : MAP_C;
      rd_en      = {rd_ok, lk_ok};
      rd_addr[0] = AW'(lin_addr(32'(lk_ch), 32'(lk_pg), 32'(lk_mp), 32'(lk_slot), SLOTS));
      rd_addr[1] = AW'(lin_addr(32'(cpu_ch), 32'(cpu_page), 32'(cpu_map), 32'(cpu_slot), SLOTS));
      wr_addr    = rd_addr[1];
   end

   cmap_store #(.DEPTH(DEPTH), .AW(AW), .DW(IDX_W), .NRD(2)) u_store (
      .clk(clk), .rst_n(rst_n), .we(wr_ok), .waddr(wr_addr), .wdata(cpu_wdata),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lk_q <= 1'b0;
         rd_q <= 1'b0;
      end else begin
         lk_q <= lk_ok;
         rd_q <= rd_ok;
      end
   end

   assign out_valid  = lk_q;
   assign out_idx    = rd_data[0];
   assign cpu_rvalid = rd_q;
   assign cpu_rdata  = rd_data[1];
endmodule

// File: rtl/cmap_conn_mem_chk.sv
module cmap_conn_mem_chk #(
   parameter int N_CH   = 4,
   parameter int SLOTS  = 12,
   parameter int IDX_W  = 10,
   localparam int CH_W   = $clog2(N_CH),
   localparam int SLOT_W = $clog2(SLOTS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_sync,
   input logic              lk_valid,
   input logic [CH_W-1:0]   lk_ch,
   input logic [SLOT_W-1:0] lk_slot,
   input logic              out_valid,
   input logic [IDX_W-1:0]  out_idx,
   input logic              cpu_rd,
   input logic [CH_W-1:0]   cpu_ch,
   input logic [SLOT_W-1:0] cpu_slot,
   input logic              cpu_rvalid,
   input logic [N_CH-1:0]   cfg_active
);
   localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);
   localparam logic [CH_W-1:0]   CH_LAST   = CH_W'(N_CH - 1);

   // R1
   reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (cfg_active == '0 && !out_valid && !cpu_rvalid));
   // R2
   lookup_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && lk_slot <= SLOT_LAST && lk_ch <= CH_LAST) |=> out_valid);
   // R2
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> (!out_valid && out_idx == '0));
   // R5
   swap_frame_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_sync |=> $stable(cfg_active));
   // R6
   readback_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && cpu_slot <= SLOT_LAST && cpu_ch <= CH_LAST) |=> cpu_rvalid);
   // R7
   bad_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && lk_slot > SLOT_LAST) |=> !out_valid);
endmodule

bind cmap_conn_mem cmap_conn_mem_chk #(.N_CH(N_CH), .SLOTS(SLOTS), .IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .lk_valid(lk_valid),
   .lk_ch(lk_ch), .lk_slot(lk_slot), .out_valid(out_valid), .out_idx(out_idx),
   .cpu_rd(cpu_rd), .cpu_ch(cpu_ch), .cpu_slot(cpu_slot), .cpu_rvalid(cpu_rvalid),
   .cfg_active(cfg_active));

// File: tb/tb_cmap_conn_mem.sv
module tb_cmap_conn_mem;
   localparam int N_CH = 4, SLOTS = 12, IDX_W = 10, CH_W = 2, SLOT_W = 4;

   logic clk = 0, rst_n = 0;
   logic frame_sync, lk_valid, cpu_wr, cpu_rd, cpu_page, cpu_map, msel_wr, swap_req;
   logic [CH_W-1:0] lk_ch, cpu_ch, msel_ch, swap_ch;
   logic [SLOT_W-1:0] lk_slot, cpu_slot;
   logic [IDX_W-1:0] cpu_wdata, out_idx, cpu_rdata;
   logic [SLOTS-1:0] msel_data;
   logic out_valid, cpu_rvalid;
   logic [N_CH-1:0] cfg_active;

   int n_tests = 0, n_fail = 0;
   logic [IDX_W-1:0] m_mem [N_CH][2][2][SLOTS];
   logic [N_CH-1:0] m_act, m_pend;
   logic [SLOTS-1:0] m_msel [N_CH];

   always #2.5 clk = ~clk;

   cmap_conn_mem #(.N_CH(N_CH), .SLOTS(SLOTS), .IDX_W(IDX_W)) dut (.*);

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   task automatic chk(bit ok, string req, int act, int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic idle();
      frame_sync = 0; lk_valid = 0; cpu_wr = 0; cpu_rd = 0; msel_wr = 0; swap_req = 0;
      lk_ch = 0; lk_slot = 0; cpu_ch = 0; cpu_page = 0; cpu_map = 0; cpu_slot = 0;
      cpu_wdata = 0; msel_ch = 0; msel_data = 0; swap_ch = 0;
   endtask

   task automatic step();
      @(posedge clk); @(negedge clk);
   endtask

   function automatic logic [IDX_W-1:0] exp_lookup(int ch, int sl);
      if (sl >= SLOTS) return '0;
      return m_mem[ch][m_act[ch]][m_msel[ch][sl]][sl];
   endfunction

   function automatic logic [IDX_W-1:0] exp_read(int ch, int pg, int mp, int sl);
      if (sl >= SLOTS) return '0;
      return m_mem[ch][pg][mp][sl];
   endfunction

   task automatic do_write(int ch, int pg, int mp, int sl, int d);
      cpu_wr = 1; cpu_ch = CH_W'(ch); cpu_page = pg[0]; cpu_map = mp[0];
      cpu_slot = SLOT_W'(sl); cpu_wdata = IDX_W'(d);
      step(); idle();
      if (sl < SLOTS && pg[0] != m_act[ch]) m_mem[ch][pg][mp][sl] = IDX_W'(d);
   endtask

   task automatic do_msel(int ch, logic [SLOTS-1:0] d);
      msel_wr = 1; msel_ch = CH_W'(ch); msel_data = d;
      step(); idle();
      m_msel[ch] = d;
   endtask

   task automatic do_swap(int ch, bit fs);
      swap_req = 1; swap_ch = CH_W'(ch); frame_sync = fs;
      step(); idle();
      if (fs) begin m_act ^= m_pend; m_pend = '0; end
      m_pend[ch] = 1'b1;
   endtask

   task automatic do_frame(string req);
      frame_sync = 1;
      step(); idle();
      m_act ^= m_pend; m_pend = '0;
      chk(cfg_active == m_act, req, cfg_active, m_act);
   endtask

   task automatic do_lookup(int ch, int sl, string req);
      logic [IDX_W-1:0] e;
      e = exp_lookup(ch, sl);
      lk_valid = 1; lk_ch = CH_W'(ch); lk_slot = SLOT_W'(sl);
      step(); idle();
      chk(out_valid == (sl < SLOTS) && out_idx == e, req, out_idx, e);
   endtask

   task automatic do_read(int ch, int pg, int mp, int sl, string req);
      logic [IDX_W-1:0] e;
      e = exp_read(ch, pg, mp, sl);
      cpu_rd = 1; cpu_ch = CH_W'(ch); cpu_page = pg[0]; cpu_map = mp[0]; cpu_slot = SLOT_W'(sl);
      step(); idle();
      chk(cpu_rvalid == (sl < SLOTS) && cpu_rdata == e, req, cpu_rdata, e);
   endtask

   initial begin
      logic [IDX_W-1:0] e0, e1;
      idle();
      m_act = '0; m_pend = '0;
      for (int c = 0; c < N_CH; c++) begin
         m_msel[c] = '0;
         for (int p = 0; p < 2; p++) for (int m = 0; m < 2; m++)
            for (int s = 0; s < SLOTS; s++) m_mem[c][p][m][s] = '0;
      end
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      chk(cfg_active == '0 && !out_valid && !cpu_rvalid, "R1", cfg_active, 0);
      do_lookup(2, 7, "R1");
      do_read(3, 1, 1, 11, "R1");

      // R4 write to standby B lands, write to active A dropped
      do_write(0, 1, 0, 3, 10'h155);
      do_read(0, 1, 0, 3, "R4");
      do_write(0, 0, 0, 3, 10'h2AA);
      do_read(0, 0, 0, 3, "R4");

      // fill standby page B of every channel
      for (int c = 0; c < N_CH; c++)
         for (int m = 0; m < 2; m++)
            for (int s = 0; s < SLOTS; s++)
               do_write(c, 1, m, s, (c * 97 + m * 31 + s * 7 + 1) % 1024);

      // R5 no swap without frame, same-cycle request waits
      do_swap(1, 0);
      chk(cfg_active == '0, "R5", cfg_active, 0);
      do_frame("R5");
      do_swap(2, 1);
      chk(cfg_active == m_act, "R5", cfg_active, m_act);
      do_frame("R5");
      // R8 only channels 1 and 2 moved
      chk(cfg_active == 4'b0110, "R8", cfg_active, 4'b0110);

      // R3 map select C and D on channel 1 (now page B)
      do_lookup(1, 4, "R3");
      do_msel(1, 12'b1000_0001_0000);
      do_lookup(1, 4, "R3");
      do_lookup(1, 11, "R3");
      do_lookup(1, 5, "R3");
      do_lookup(0, 4, "R8");

      // R7 illegal slots
      for (int s = SLOTS; s < 16; s++) begin
         do_lookup(1, s, "R7");
         do_read(1, 1, 0, s, "R7");
         do_write(1, 0, 0, s, 10'h3FF);
      end
      do_read(1, 0, 0, 11, "R7");

      // R6 read and write same entry in one cycle return old value
      e0 = exp_read(3, 1, 1, 6);
      cpu_rd = 1; cpu_wr = 1; cpu_ch = 3; cpu_page = 1; cpu_map = 1; cpu_slot = 6; cpu_wdata = 10'h0F0;
      step(); idle();
      chk(cpu_rvalid && cpu_rdata == e0, "R6", cpu_rdata, e0);
      m_mem[3][1][1][6] = 10'h0F0;
      do_read(3, 1, 1, 6, "R6");

      // R6 concurrent lookup and read-back
      e0 = exp_lookup(2, 9); e1 = exp_read(0, 1, 1, 2);
      lk_valid = 1; lk_ch = 2; lk_slot = 9;
      cpu_rd = 1; cpu_ch = 0; cpu_page = 1; cpu_map = 1; cpu_slot = 2;
      step(); idle();
      chk(out_valid && out_idx == e0, "R6", out_idx, e0);
      chk(cpu_rvalid && cpu_rdata == e1, "R6", cpu_rdata, e1);

      // random mix
      for (int i = 0; i < 600; i++) begin
         int op, c, s;
         op = $urandom_range(0, 9);
         c  = $urandom_range(0, N_CH - 1);
         s  = $urandom_range(0, 15);
         case (op)
            0, 1: do_write(c, $urandom_range(0, 1), $urandom_range(0, 1), s, $urandom_range(0, 1023));
            2:    do_msel(c, SLOTS'($urandom));
            3:    do_swap(c, $urandom_range(0, 3) == 0);
            4:    do_frame("R5");
            5, 6, 7: do_lookup(c, s, "R2");
            default: do_read(c, $urandom_range(0, 1), $urandom_range(0, 1), s, "R6");
         endcase
      end
      do_lookup(0, 0, "R2");

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule